// File: doc/BRIEF.md
# Configuration Address/Data Port Unit

This block sits behind an eight-byte I/O window and lets a host reach configuration space in two steps. First the host writes a 32-bit target address into an address latch at window bytes 0 to 3. Then it reads or writes the data port at window bytes 4 to 7. Each host access carries a byte offset into the window, a size of 1, 2 or 4 bytes, and a read/write flag. Data travels in little-endian order: the first byte sits in the low lane.

The latch carries an enable flag in its top bit. The block splits the latch into bus, device, function and dword-register fields. While the enable flag is set, each data-port access becomes a request to a configuration dispatcher. That dispatcher returns the addressed dword in the same cycle. While the flag is clear, data-port traffic never reaches the dispatcher. The block does not hold configuration registers of its own.

Host reads return their data one cycle after the access. A read takes its bytes starting at lane (offset mod 4) and fills lanes beyond the access size with zero.

Top module: `cfgio_port_unit`

## Requirements
- R1: After reset the address latch holds zero, so the enable flag is clear, no read response is pending and no dispatcher request is issued.
- R2: A 4-byte write at window offset 0 replaces the whole latch with the write data, taken as a little-endian value, and a 4-byte read at offset 0 returns it.
- R3: A 1- or 2-byte latch write at offset k changes only latch byte lanes k up to k+size-1, filled from the low bytes of the write data in order. All other latch bits keep their value, and the latch changes on no other access.
- R4: A latch write whose size is not 1, 2 or 4, or whose offset plus size exceeds 4, leaves the latch unchanged.
- R5: A read returns the source dword shifted right by 8 times (offset mod 4) bits, with lanes at and above the access size forced to zero. The source dword is the latch for offsets 0 to 3 and configuration data for offsets 4 to 7.
- R6: A read whose starting lane plus size exceeds 4 returns 0xFFFFFFFF and issues no dispatcher request.
- R7: While latch bit 31 is clear, a data-port read issues no request and returns 0xFFFFFFFF before lane selection, and a data-port write issues no request.
- R8: Requests carry bus = latch bits 23:16, device = bits 15:11, function = bits 10:8 and register index = bits 7:2. Latch bits 30:24 and 1:0 play no part in routing.
- R9: An enabled data-port write of size 1, 2 or 4 that stays inside the dword issues one write request in the same cycle. The request carries byte offset (offset - 4), the access size and the write data unchanged. A data-port write that crosses the dword or has any other size issues no request.
- R10: An enabled, in-bounds data-port read issues a read request in the same cycle. Its response is the dispatcher's returned dword, with lanes selected as in R5.
- R11: The read-valid output is high exactly in the cycle after each read access, whatever its offset, and low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access strobe for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 3 | Byte offset within the eight-byte window |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data, first byte in bits 7:0 |
| acc_rvalid | output | 1 | Read response valid, one cycle after the read |
| acc_rdata | output | 32 | Read response data, first byte in bits 7:0 |
| cfg_req_valid | output | 1 | Dispatcher request strobe |
| cfg_req_write | output | 1 | Dispatcher request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_func | output | 3 | Target function number |
| cfg_reg | output | 6 | Target dword register index |
| cfg_byte_off | output | 2 | Byte offset of a write inside the dword |
| cfg_size | output | 3 | Size of the request in bytes |
| cfg_wdata | output | 32 | Write data passed to the dispatcher |
| cfg_rdata | input | 32 | Dword returned by the dispatcher in the request cycle |

## Verification
The read response of one access is still on the outputs while the next access may already be rewriting the latch. The bench provokes this with a data-port read and, in the very next cycle, a latch write that clears the enable flag. In that second cycle it checks that the response carries the dispatcher data chosen under the old latch value. A read in the cycle after the write must then see the disabled state and produce no request. Row-by-row table checks cover lane merging, out-of-range suppression and the all-ones fill.

// File: rtl/cfgio_pkg.sv
// Package: shared widths, latch field positions and access-shape helpers
// for the configuration port unit. Assumes a 32-bit latch and dword data.
package cfgio_pkg;

    localparam int DW      = 32;
    localparam int LANES   = DW / 8;
    localparam int OFF_W   = 3;
    localparam int SZ_W    = 3;

    localparam int EN_BIT  = 31;
    localparam int BUS_LSB = 16;
    localparam int BUS_W   = 8;
    localparam int DEV_LSB = 11;
    localparam int DEV_W   = 5;
    localparam int FN_LSB  = 8;
    localparam int FN_W    = 3;
    localparam int REG_LSB = 2;
    localparam int REG_W   = 6;

    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  func;
        logic [REG_W-1:0] reg_idx;
    } cfg_target_t;

    // True for the sizes a write may carry.
    function automatic logic size_ok(input logic [SZ_W-1:0] size);
        return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
    endfunction

    // True when an access starting at lane 'start' stays inside one dword.
    function automatic logic span_ok(input logic [1:0] start,
                                     input logic [SZ_W-1:0] size);
        logic [3:0] sum;
        sum = {2'b00, start} + {1'b0, size};
        return sum <= 4'd4;
    endfunction

endpackage

// File: rtl/cfgio_addr_latch.sv
// Address latch: holds the 32-bit configuration target and merges latch
// writes byte lane by byte lane. Assumes the caller asserts wr_en only for
// writes aimed at window bytes 0 to 3; shape checks are done here.
module cfgio_addr_latch
    import cfgio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           lane_off,
    input  logic [SZ_W-1:0]      size,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        latch_q
);

    logic [LANES-1:0] hit;
    logic [DW-1:0]    placed;
    logic [3:0]       lane_end;
    logic             shape_ok;

    // Place write bytes on their target lanes and bound the covered range.
    always_comb begin
        placed   = wdata << {lane_off, 3'b000};
        lane_end = {2'b00, lane_off} + {1'b0, size};
        shape_ok = wr_en && size_ok(size) && span_ok(lane_off, size);
    end

    // One hit flag per lane: lane lies inside [lane_off, lane_end).
    for (genvar i = 0; i < LANES; i++) begin : g_lane_hit
        assign hit[i] = shape_ok && (4'(i) >= {2'b00, lane_off}) && (4'(i) < lane_end);
    end

    // Register: clear on reset, otherwise replace only the hit lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (hit[i]) latch_q[8*i +: 8] <= placed[8*i +: 8];
            end
        end
    end

endmodule

// File: rtl/cfgio_decode.sv
// Field decoder: splits the latch into routing fields and the enable flag.
// Assumes the fixed field layout of the package; bits 30:24 and 1:0 unused.
module cfgio_decode
    import cfgio_pkg::*;
(
    input  logic [DW-1:0] latch_q,
    output cfg_target_t   tgt,
    output logic          enabled
);

    // Pure slicing of the latch into the target record.
    always_comb begin
        enabled     = latch_q[EN_BIT];
        tgt.bus     = latch_q[BUS_LSB +: BUS_W];
        tgt.dev     = latch_q[DEV_LSB +: DEV_W];
        tgt.func    = latch_q[FN_LSB +: FN_W];
        tgt.reg_idx = latch_q[REG_LSB +: REG_W];
    end

endmodule

// File: rtl/cfgio_read_path.sv
// Read path: picks the source dword, applies lane selection and size mask,
// and registers the response one cycle after the read. Assumes the
// dispatcher's dword is valid in the request cycle.
module cfgio_read_path
    import cfgio_pkg::*;
#(
    parameter logic [DW-1:0] FILL = '1
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_fire,
    input  logic [1:0]      lane_start,
    input  logic [SZ_W-1:0] size,
    input  logic            from_data,
    input  logic            enabled,
    input  logic [DW-1:0]   latch_q,
    input  logic [DW-1:0]   cfg_rdata,
    output logic            rvalid,
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0]    src;
    logic [DW-1:0]    shifted;
    logic [DW-1:0]    masked;
    logic [DW-1:0]    result;
    logic [LANES-1:0] keep;

    // Choose the dword the read draws from and move its start lane down.
    always_comb begin
        if (!from_data)    src = latch_q;
        else if (enabled)  src = cfg_rdata;
        else               src = FILL;
        shifted = src >> {lane_start, 3'b000};
    end

    // Keep only the lanes the access size covers.
    for (genvar i = 0; i < LANES; i++) begin : g_lane_keep
        assign keep[i] = size > SZ_W'(i);
        assign masked[8*i +: 8] = keep[i] ? shifted[8*i +: 8] : 8'h00;
    end

    // Out-of-dword reads return the fill pattern in every byte.
    assign result = span_ok(lane_start, size) ? masked : FILL;

    // Response register: valid one cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_fire;
            if (rd_fire) rdata <= result;
        end
    end

endmodule

// File: rtl/cfgio_port_unit.sv
// Top: eight-byte address/data window into configuration space. Bytes 0-3
// reach the address latch, bytes 4-7 become dispatcher requests when the
// latch enable flag is set. Assumes one host access per cycle and a
// dispatcher that answers reads combinationally.
module cfgio_port_unit
    import cfgio_pkg::*;
#(
    parameter logic [31:0] FILL = 32'hFFFF_FFFF
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [2:0]  acc_offset,
    input  logic [2:0]  acc_size,
    input  logic [31:0] acc_wdata,
    output logic        acc_rvalid,
    output logic [31:0] acc_rdata,
    output logic        cfg_req_valid,
    output logic        cfg_req_write,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_func,
    output logic [5:0]  cfg_reg,
    output logic [1:0]  cfg_byte_off,
    output logic [2:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic [31:0] cfg_rdata
);

    logic [DW-1:0] latch_q;
    cfg_target_t   tgt;
    logic          enabled;
    logic          data_sel;
    logic [1:0]    lane_start;
    logic          latch_wr;
    logic          rd_fire;
    logic          shape_ok;

    // Classify the incoming access.
    always_comb begin
        data_sel   = acc_offset[OFF_W-1];
        lane_start = acc_offset[1:0];
        latch_wr   = acc_valid && acc_write && !data_sel;
        rd_fire    = acc_valid && !acc_write;
        shape_ok   = span_ok(lane_start, acc_size) &&
                     (acc_write ? size_ok(acc_size) : (acc_size != '0));
    end

    cfgio_addr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (latch_wr),
        .lane_off (lane_start),
        .size     (acc_size),
        .wdata    (acc_wdata),
        .latch_q  (latch_q)
    );

    cfgio_decode u_decode (
        .latch_q (latch_q),
        .tgt     (tgt),
        .enabled (enabled)
    );

    cfgio_read_path #(.FILL(FILL)) u_read (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fire    (rd_fire),
        .lane_start (lane_start),
        .size       (acc_size),
        .from_data  (data_sel),
        .enabled    (enabled),
        .latch_q    (latch_q),
        .cfg_rdata  (cfg_rdata),
        .rvalid     (acc_rvalid),
        .rdata      (acc_rdata)
    );

    // Dispatcher request: only enabled, well-shaped data-port accesses.
    always_comb begin
        cfg_req_valid = acc_valid && data_sel && enabled && shape_ok;
        cfg_req_write = acc_write;
        cfg_bus       = tgt.bus;
        cfg_dev       = tgt.dev;
        cfg_func      = tgt.func;
        cfg_reg       = tgt.reg_idx;
        cfg_byte_off  = lane_start;
        cfg_size      = acc_size;
        cfg_wdata     = acc_wdata;
    end

endmodule

// File: rtl/cfgio_port_unit_sva.sv
// Checker: temporal properties of the port unit, bound to the top module.
// Assumes access to the latch register through the bind connection.
module cfgio_port_unit_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [2:0]  acc_offset,
    input logic [2:0]  acc_size,
    input logic        acc_rvalid,
    input logic [31:0] acc_rdata,
    input logic        cfg_req_valid,
    input logic        cfg_req_write,
    input logic [1:0]  cfg_byte_off,
    input logic [31:0] latch_q
);

    logic [3:0] span;
    assign span = {2'b00, acc_offset[1:0]} + {1'b0, acc_size};

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == 32'h0) && !acc_rvalid);

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && !acc_offset[2]) |=> $stable(latch_q));

    assert_oob_read_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && span > 4'd4) |=> (acc_rdata == 32'hFFFF_FFFF));

    assert_oob_read_noreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && span > 4'd4) |-> !cfg_req_valid);

    assert_req_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> latch_q[31]);

    assert_write_req_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_valid && cfg_req_write) |->
            acc_offset[2] && (cfg_byte_off == acc_offset[1:0]) && (span <= 4'd4));

    assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> acc_rvalid);

    assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !acc_rvalid);

endmodule

bind cfgio_port_unit cfgio_port_unit_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_valid     (acc_valid),
    .acc_write     (acc_write),
    .acc_offset    (acc_offset),
    .acc_size      (acc_size),
    .acc_rvalid    (acc_rvalid),
    .acc_rdata     (acc_rdata),
    .cfg_req_valid (cfg_req_valid),
    .cfg_req_write (cfg_req_write),
    .cfg_byte_off  (cfg_byte_off),
    .latch_q       (latch_q)
);

// File: tb/cfgio_port_unit_test.sv
// Bench: table-driven walk of latch and data-port accesses, then directed
// tests for field routing, back-to-back overlap and mid-run reset.
module cfgio_port_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_offset = '0;
    logic [2:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;
    logic        cfg_req_valid;
    logic        cfg_req_write;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_reg;
    logic [1:0]  cfg_byte_off;
    logic [2:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    // Dispatcher model: a dword that depends on the register index.
    assign cfg_rdata = 32'h1122_3344 ^ {26'd0, cfg_reg};

    cfgio_port_unit uut (.*);

    // Row: tag, wr, off, size, wdata, expected request, expected read data.
    typedef logic [79:0] vec_t;
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        {8'd7,  1'b0, 3'd4, 3'd4, 32'h0000_0000, 1'b0, 32'hFFFF_FFFF}, // R7 disabled read
        {8'd7,  1'b1, 3'd4, 3'd4, 32'h0000_1234, 1'b0, 32'h0},         // R7 disabled write
        {8'd2,  1'b1, 3'd0, 3'd4, 32'h8001_2A0C, 1'b0, 32'h0},         // R2 full latch write
        {8'd2,  1'b0, 3'd0, 3'd4, 32'h0,         1'b0, 32'h8001_2A0C}, // R2 read back
        {8'd10, 1'b0, 3'd4, 3'd4, 32'h0,         1'b1, 32'h1122_3347}, // R10 enabled read
        {8'd3,  1'b1, 3'd1, 3'd1, 32'h0000_002F, 1'b0, 32'h0},         // R3 byte lane 1
        {8'd3,  1'b0, 3'd0, 3'd4, 32'h0,         1'b0, 32'h8001_2F0C}, // R3 merge result
        {8'd3,  1'b1, 3'd2, 3'd2, 32'h0000_7702, 1'b0, 32'h0},         // R3 upper half
        {8'd7,  1'b0, 3'd6, 3'd2, 32'h0,         1'b0, 32'h0000_FFFF}, // R7 fill then lanes
        {8'd3,  1'b1, 3'd3, 3'd1, 32'h0000_0080, 1'b0, 32'h0},         // R3 set enable only
        {8'd4,  1'b1, 3'd3, 3'd2, 32'h0000_FFFF, 1'b0, 32'h0},         // R4 crosses dword
        {8'd4,  1'b1, 3'd0, 3'd3, 32'h00FF_FFFF, 1'b0, 32'h0},         // R4 bad size
        {8'd4,  1'b0, 3'd0, 3'd4, 32'h0,         1'b0, 32'h8002_2F0C}, // R4 latch unchanged
        {8'd5,  1'b0, 3'd1, 3'd2, 32'h0,         1'b0, 32'h0000_022F}, // R5 latch lanes 1-2
        {8'd5,  1'b0, 3'd3, 3'd1, 32'h0,         1'b0, 32'h0000_0080}, // R5 top lane
        {8'd6,  1'b0, 3'd2, 3'd4, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6 latch overrun
        {8'd6,  1'b0, 3'd5, 3'd4, 32'h0,         1'b0, 32'hFFFF_FFFF}, // R6 data overrun
        {8'd5,  1'b0, 3'd5, 3'd2, 32'h0,         1'b1, 32'h0000_2233}, // R5 data lanes
        {8'd9,  1'b1, 3'd6, 3'd2, 32'h0000_BEEF, 1'b1, 32'h0},         // R9 write issued
        {8'd9,  1'b1, 3'd7, 3'd2, 32'h0000_BEEF, 1'b0, 32'h0},         // R9 crossing write
        {8'd9,  1'b1, 3'd4, 3'd3, 32'h0000_0000, 1'b0, 32'h0},         // R9 bad size write
        {8'd10, 1'b0, 3'd4, 3'd4, 32'h0,         1'b1, 32'h1122_3347}, // R10 full dword
        {8'd5,  1'b0, 3'd5, 3'd3, 32'h0,         1'b1, 32'h0011_2233}  // R5 three bytes
    };

    task automatic check(input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [2:0] off,
                         input logic [2:0] sz, input logic [31:0] d);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = off;
        acc_size   = sz;
        acc_wdata  = d;
    endtask

    task automatic idle();
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(1, "rvalid after reset", {31'd0, acc_rvalid}, 32'd0);
        check(1, "no request after reset", {31'd0, cfg_req_valid}, 32'd0);

        // Table walk: one access, request checked in-cycle, response next cycle.
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            @(negedge clk);
            drive(v[71], v[70:68], v[67:65], v[64:33]);
            #1;
            check(int'(v[79:72]), $sformatf("request row %0d", i),
                  {31'd0, cfg_req_valid}, {31'd0, v[32]});
            if (v[71] && v[32]) begin
                check(9, "write byte offset", {30'd0, cfg_byte_off}, {30'd0, v[69:68] - 2'd0});
                check(9, "write size", {29'd0, cfg_size}, {29'd0, v[67:65]});
                check(9, "write data", cfg_wdata, v[64:33]);
                check(9, "write flag", {31'd0, cfg_req_write}, 32'd1);
            end
            @(negedge clk);
            idle();
            check(11, $sformatf("rvalid row %0d", i), {31'd0, acc_rvalid}, {31'd0, ~v[71]});
            if (!v[71])
                check(int'(v[79:72]), $sformatf("rdata row %0d", i), acc_rdata, v[31:0]);
        end

        // R8: field routing with the unused bits set.
        @(negedge clk);
        drive(1'b1, 3'd0, 3'd4, 32'hFF5A_C8D7);
        @(negedge clk);
        drive(1'b0, 3'd4, 3'd4, 32'h0);
        #1;
        check(8, "bus field", {24'd0, cfg_bus}, 32'h5A);
        check(8, "device field", {27'd0, cfg_dev}, 32'd25);
        check(8, "function field", {29'd0, cfg_func}, 32'd0);
        check(8, "register field", {26'd0, cfg_reg}, 32'd53);
        check(10, "read request flag", {30'd0, cfg_req_valid, cfg_req_write}, 32'd2);

        // R11 overlap: latch write disabling access lands while the read response shows.
        @(negedge clk);
        drive(1'b1, 3'd3, 3'd1, 32'h0000_0000);
        check(11, "overlap rvalid", {31'd0, acc_rvalid}, 32'd1);
        check(10, "overlap rdata under old latch", acc_rdata, 32'h1122_3371);
        @(negedge clk);
        drive(1'b0, 3'd4, 3'd4, 32'h0);
        #1;
        check(7, "no request once disabled", {31'd0, cfg_req_valid}, 32'd0);
        check(11, "rvalid low after write", {31'd0, acc_rvalid}, 32'd0);
        @(negedge clk);
        idle();
        check(7, "disabled data read", acc_rdata, 32'hFFFF_FFFF);
        check(11, "rvalid after read", {31'd0, acc_rvalid}, 32'd1);

        // R1: mid-run reset clears the latch.
        @(negedge clk);
        drive(1'b1, 3'd0, 3'd4, 32'h8012_3456);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(1, "rvalid cleared by reset", {31'd0, acc_rvalid}, 32'd0);
        drive(1'b0, 3'd0, 3'd4, 32'h0);
        @(negedge clk);
        idle();
        check(1, "latch cleared by reset", acc_rdata, 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R11 watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule